// File: doc/BRIEF.md
# Mailbox Message Framer

The framer turns one stored payload into a complete outbound message. It writes that message one byte at a time into a device-to-host mailbox FIFO. When `start` is pulsed, the framer captures an endpoint number, a flags byte, a 16-bit control word and a payload length. It then emits a six-byte header and reads the payload from an external byte buffer through a combinational address/data pair. After the payload it appends zero bytes until the frame length is a whole number of pad blocks (128 bytes by default).

The framer writes only in cycles where the FIFO reports room, so a full FIFO stalls the frame without losing any byte. `busy` is high for the whole frame. `done` pulses once after the final byte has been written. The framer accepts a new `start` only when it is idle.

Top module: `mbox_framer`

## Requirements
- R1: After reset `busy`, `done` and `fifo_wr` are all low.
- R2: Frame byte 0 is the captured endpoint number and byte 1 is the captured flags byte.
- R3: Frame bytes 2 and 3 are the payload length as a 16-bit value: byte 2 is bits 7:0 and byte 3 is bits 15:8.
- R4: Frame bytes 4 and 5 are the control word: byte 4 is bits 7:0 and byte 5 is bits 15:8.
- R5: Frame bytes 6 to 6+len-1 are the buffer bytes at addresses 0 to len-1, in ascending order.
- R6: After the payload, the framer writes zero bytes until the total frame length is the smallest multiple of 2^PAD_LOG2 (128) that is at least 6+len.
- R7: `fifo_wr` is never high while `fifo_full` is high. A full cycle holds the frame position, and no byte is dropped or repeated.
- R8: `done` is high for exactly one cycle, the cycle after the edge that writes the last byte. `busy` is low in that same cycle.
- R9: A `start` pulse while `busy` is high has no effect. The running frame and its captured fields are unchanged.
- R10: A zero-length payload gives a 128-byte frame: the six header bytes with length 0, followed by 122 zero bytes.
- R11: `fifo_wr` is high only while `busy` is high. No byte is written when idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a frame; accepted only when idle |
| ep_id | input | 8 | Endpoint number, captured at start |
| flags_in | input | 8 | Flags byte, captured at start |
| ctrl_in | input | 16 | Control word, captured at start |
| pay_len | input | LW (9) | Payload length in bytes, 0 to MAX_LEN |
| pay_addr | output | AW (8) | Payload buffer read address |
| pay_data | input | 8 | Payload buffer byte at `pay_addr`, same cycle |
| fifo_full | input | 1 | Mailbox FIFO has no room |
| fifo_wr | output | 1 | Write strobe into the mailbox FIFO |
| fifo_data | output | 8 | Byte to be written |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the last byte |

## Verification
The bound checker watches several rules on every cycle:
- no write into a full FIFO and no write while idle;
- `done` lasts one cycle and always follows a write;
- a full FIFO never ends a frame;
- the number of bytes written between two `done` pulses is a non-zero multiple of the pad block.

Only the bench scenarios can show the content of the frame: the header byte order, payload ordering against the buffer, zero-valued padding, correct total lengths at the 122/123-byte boundary and at the maximum length, and that a mid-frame `start` leaves the captured fields alone.

// File: rtl/mbox_framer.sv
module mbox_framer #(
  parameter int MAX_LEN  = 256,
  parameter int PAD_LOG2 = 7,
  localparam int LW = $clog2(MAX_LEN + 1),
  localparam int AW = $clog2(MAX_LEN),
  localparam int CW = $clog2(MAX_LEN + 6 + (1 << PAD_LOG2))
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    ep_id,
  input  logic [7:0]    flags_in,
  input  logic [15:0]   ctrl_in,
  input  logic [LW-1:0] pay_len,
  output logic [AW-1:0] pay_addr,
  input  logic [7:0]    pay_data,
  input  logic          fifo_full,
  output logic          fifo_wr,
  output logic [7:0]    fifo_data,
  output logic          busy,
  output logic          done
);
  localparam int PAD = 1 << PAD_LOG2;

  logic [7:0]    ep_q, fl_q;
  logic [15:0]   ct_q;
  logic [LW-1:0] len_q;
  logic [CW-1:0] pos;
  logic [CW-1:0] span, total, pay_end;
  logic          last;

  assign span     = CW'(len_q) + CW'(6 + PAD - 1);
  assign total    = {span[CW-1:PAD_LOG2], {PAD_LOG2{1'b0}}};
  assign pay_end  = CW'(len_q) + CW'(6);
  assign last     = (pos == total - CW'(1));
  assign fifo_wr  = busy & ~fifo_full;
  assign pay_addr = AW'(pos - CW'(6));

  always_comb begin
    case (pos)
      CW'(0):  fifo_data = ep_q;
      CW'(1):  fifo_data = fl_q;
      CW'(2):  fifo_data = 8'(16'(len_q));
      CW'(3):  fifo_data = 8'(16'(len_q) >> 8);
      CW'(4):  fifo_data = ct_q[7:0];
      CW'(5):  fifo_data = ct_q[15:8];
      default: fifo_data = (pos < pay_end) ? pay_data : 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      pos   <= '0;
      ep_q  <= '0;
      fl_q  <= '0;
      ct_q  <= '0;
      len_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          pos   <= '0;
          ep_q  <= ep_id;
          fl_q  <= flags_in;
          ct_q  <= ctrl_in;
          len_q <= pay_len;
        end
      end else if (fifo_wr) begin
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          pos <= pos + CW'(1);
        end
      end
    end
  end
endmodule

module mbox_framer_chk #(
  parameter int PAD_LOG2 = 7
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic fifo_wr,
  input logic fifo_full
);
  logic [15:0] wr_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wr_count <= '0;
    else if (done)    wr_count <= '0;
    else if (fifo_wr) wr_count <= wr_count + 16'd1;
  end

  assert_wr_not_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> !fifo_full);
  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fifo_full) |=> busy);
  assert_wr_only_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> busy);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(fifo_wr) && !busy));
  assert_frame_multiple_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_count != 16'd0 && wr_count[PAD_LOG2-1:0] == '0));
endmodule

bind mbox_framer mbox_framer_chk #(.PAD_LOG2(PAD_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .fifo_wr(fifo_wr), .fifo_full(fifo_full)
);

// File: tb/test_mbox_framer.sv
module test_mbox_framer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  ep_id = '0, flags_in = '0;
  logic [15:0] ctrl_in = '0;
  logic [8:0]  pay_len = '0;
  logic [7:0]  pay_addr;
  logic [7:0]  pay_data;
  logic        fifo_full = 1'b0;
  logic        fifo_wr;
  logic [7:0]  fifo_data;
  logic        busy, done;

  logic [7:0] mem [0:255];
  logic [7:0] got [0:1023];
  int n_checks = 0, n_fail = 0;

  assign pay_data = mem[pay_addr];

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_framer i_mbox_framer (
    .clk(clk), .rst_n(rst_n), .start(start), .ep_id(ep_id), .flags_in(flags_in),
    .ctrl_in(ctrl_in), .pay_len(pay_len), .pay_addr(pay_addr), .pay_data(pay_data),
    .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input int len, input logic [7:0] ep, input logic [7:0] fl,
                           input logic [15:0] ct, input bit stall, input bit poke);
    int n = 0, dones = 0, wr_full = 0, cyc = 0, after = -1, late_wr = 0;
    int exp_total, bad_pay = 0, bad_pad = 0;
    bit busy_after_done = 0;
    exp_total = ((6 + len + 127) / 128) * 128;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 13 + len + 5);
    @(negedge clk);
    ep_id = ep; flags_in = fl; ctrl_in = ct; pay_len = 9'(len); start = 1'b1;
    while (after < 4 && cyc < 3000) begin
      @(negedge clk);
      start = poke && (cyc == 20);
      if (poke) begin ep_id = ~ep; flags_in = ~fl; ctrl_in = ~ct; pay_len = 9'd1; end
      fifo_full = stall && (cyc % 3 == 1);
      #1;
      if (fifo_wr && fifo_full) wr_full++;
      if (fifo_wr) begin
        if (after >= 0) late_wr++;
        else if (n < 1024) begin got[n] = fifo_data; n++; end
      end
      if (done) begin dones++; if (busy) busy_after_done = 1; end
      if (after >= 0) after++;
      else if (done) after = 0;
      cyc++;
    end
    start = 1'b0; fifo_full = 1'b0;
    chk(n == exp_total, (len == 0) ? "R10 zero-length total" : "R6 frame total", n, exp_total);
    chk(got[0] == ep && got[1] == fl, poke ? "R9/R2 header ep+flags" : "R2 header ep+flags",
        {got[0], got[1]}, {ep, fl});
    chk(got[2] == 8'(len) && got[3] == 8'(len >> 8), "R3 length LSB first",
        {got[3], got[2]}, len);
    chk(got[4] == ct[7:0] && got[5] == ct[15:8], "R4 control LSB first",
        {got[5], got[4]}, ct);
    for (int i = 0; i < len; i++) if (got[6+i] !== mem[i]) bad_pay++;
    chk(bad_pay == 0, "R5 payload order", bad_pay, 0);
    for (int i = 6 + len; i < n; i++) if (got[i] !== 8'h00) bad_pad++;
    chk(bad_pad == 0, "R6 pad bytes zero", bad_pad, 0);
    chk(dones == 1 && !busy_after_done, "R8 single done pulse", dones, 1);
    chk(late_wr == 0, "R11 no write when idle", late_wr, 0);
    if (stall) chk(wr_full == 0, "R7 no write while full", wr_full, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !fifo_wr, "R1 reset state", {busy, done, fifo_wr}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!busy && !fifo_wr, "R11 idle no write", {busy, fifo_wr}, 0);
    run_frame(0,   8'h00, 8'h00, 16'h0000, 0, 0);
    run_frame(5,   8'h01, 8'h80, 16'hA55A, 0, 0);
    run_frame(122, 8'h02, 8'h11, 16'h1234, 1, 0);
    run_frame(123, 8'h03, 8'h22, 16'hBEEF, 0, 0);
    run_frame(256, 8'h7F, 8'hC3, 16'h8001, 1, 0);
    run_frame(40,  8'h44, 8'h55, 16'h6677, 1, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule